// File: doc/BRIEF.md
# Single-Slave SPI Master with Setup Wait and Ready Gating

This block is a full-duplex serial master for a single slave. A host presents a transmit word, a two-bit clock mode, a bit-order flag, a clock divider value and a setup wait count, and pulses a start input. The block drops the active-low chip select and waits for the programmed number of system cycles. It then holds off until the slave's active-low ready input is low. After that it clocks out one word of `WIDTH` bits while it samples the incoming serial line. At the end it releases chip select and presents the received word with a one-cycle done pulse.

The serial clock is made from the system clock by a half-period divider. All four polarity and phase combinations are supported. Bits may go out most-significant first or least-significant first. A start pulse that arrives while a word is in flight has no effect.

Top module: `spi_flow_master`

## Requirements
- R1: `mode_i[1]` is the clock polarity and `mode_i[0]` the clock phase (mode number = {polarity, phase}). `sclk_o` rests at the polarity level whenever `cs_no` is high, when `cs_no` falls, and after the word ends.
- R2: With phase 0, the first data bit is on `mosi_o` as soon as `cs_no` falls. `mosi_o` changes on the edges that return `sclk_o` to its rest level, and `miso_i` is sampled on the edges that leave it.
- R3: With phase 1, `mosi_o` changes on the edges leaving the rest level and is valid from the first such edge. `miso_i` is sampled on the edges returning to the rest level.
- R4: With `lsb_first_i`=0, bit WIDTH-1 of `tx_data_i` goes out first, and each sampled bit enters `rx_data_o` at bit 0 while earlier bits move up. With `lsb_first_i`=1, bit 0 goes out first, and each sampled bit enters at bit WIDTH-1 while earlier bits move down. In both orders, a slave sending word X in the same order yields `rx_data_o` = X.
- R5: Every word has exactly 2*WIDTH `sclk_o` transitions, spaced `half_div_i`+1 system cycles apart.
- R6: `cs_no` goes low in the cycle after an accepted start. It returns high one half period after the last `sclk_o` transition, in the same cycle as `done_o`.
- R7: The first `sclk_o` transition comes exactly `wait_cycles_i` + `half_div_i` + 2 system cycles after `cs_no` falls, with `ready_ni` low.
- R8: While `ready_ni` is high once the setup wait has expired, `sclk_o` holds its rest level, `cs_no` stays low and no `done_o` is given. The word proceeds once `ready_ni` goes low.
- R9: A start pulse while `busy_o` is high is ignored: the word in flight keeps its data, and no further word follows it.
- R10: `done_o` is high for exactly one cycle per word. `rx_data_o` holds the received word from that cycle until the next `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| tx_data_i | input | WIDTH | Word to transmit |
| mode_i | input | 2 | {polarity, phase} |
| lsb_first_i | input | 1 | 1 = least-significant bit first |
| half_div_i | input | DIV_W | SCLK half period minus one, in system cycles |
| wait_cycles_i | input | WAIT_W | Setup wait after chip select falls |
| ready_ni | input | 1 | Slave ready, active low |
| miso_i | input | 1 | Serial data from slave |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to slave |
| cs_no | output | 1 | Chip select, active low |
| rx_data_o | output | WIDTH | Received word |
| done_o | output | 1 | One-cycle word-complete pulse |
| busy_o | output | 1 | Word in progress |

## Verification
`cs_no` falls one cycle after start is sampled. The first `sclk_o` transition follows `wait_cycles_i`+`half_div_i`+2 cycles later. `done_o` and the rise of `cs_no` come one half period after the 2*WIDTH-th transition. The bench samples at falling system-clock edges. It counts cycles from the fall of `cs_no` to test the exact first-edge latency, and it polls for `done_o` instead of predicting its edge; it then checks data, chip select and clock level in that same sample. A behavioural slave reacts to `sclk_o` transitions according to the mode. Its captured word and the word it sent are compared with the transmit word and with `rx_data_o`.

// File: rtl/spi_flow_pkg.sv
package spi_flow_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_XFER  = 2'd2,
    ST_LAST  = 2'd3
  } seq_state_e;

  localparam int unsigned MODE_CPOL_BIT = 1;
  localparam int unsigned MODE_CPHA_BIT = 0;
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == half_div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assert_tick_spacing_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && half_div_i != '0 |=> !tick_o);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] tx_i,
  input  logic             lsb_first_i,
  input  logic             shift_i,
  input  logic             sample_i,
  input  logic             capture_i,
  input  logic             miso_i,
  output logic             mosi_o,
  output logic [WIDTH-1:0] rx_o
);
  logic [WIDTH-1:0] tx_q, rx_q, rx_out_q;
  logic             lsb_q;

  assign mosi_o = lsb_q ? tx_q[0] : tx_q[WIDTH-1];
  assign rx_o   = rx_out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q     <= '0;
      rx_q     <= '0;
      rx_out_q <= '0;
      lsb_q    <= 1'b0;
    end else begin
      if (load_i) begin
        tx_q  <= tx_i;
        lsb_q <= lsb_first_i;
        rx_q  <= '0;
      end else if (shift_i) begin
        tx_q <= lsb_q ? {1'b0, tx_q[WIDTH-1:1]} : {tx_q[WIDTH-2:0], 1'b0};
      end
      if (sample_i)
        rx_q <= lsb_q ? {miso_i, rx_q[WIDTH-1:1]} : {rx_q[WIDTH-2:0], miso_i};
      if (capture_i)
        rx_out_q <= rx_q;
    end
  end

  assert_one_event_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({load_i, shift_i, sample_i}));
  assert_mosi_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !shift_i |=> $stable(mosi_o));
endmodule

// File: rtl/spi_seq.sv
module spi_seq
  import spi_flow_pkg::*;
#(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned WAIT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [WAIT_W-1:0] wait_cycles_i,
  input  logic              ready_ni,
  input  logic              tick_i,
  output logic              run_o,
  output logic              load_o,
  output logic              shift_o,
  output logic              sample_o,
  output logic              capture_o,
  output logic              sclk_o,
  output logic              cs_no,
  output logic              done_o,
  output logic              busy_o
);
  localparam int unsigned NUM_EDGES = 2 * WIDTH;
  localparam int unsigned EC_W      = $clog2(NUM_EDGES + 1);
  localparam logic [EC_W-1:0] LAST_EDGE = EC_W'(NUM_EDGES - 1);

  seq_state_e        st_q;
  logic [WAIT_W-1:0] wait_q;
  logic [EC_W-1:0]   edge_q;
  logic              sclk_q, cs_q, done_q, cpol_q, cpha_q;
  logic              xfer_tick, leading;

  assign xfer_tick = (st_q == ST_XFER) && tick_i;
  assign leading   = ~edge_q[0];
  assign run_o     = (st_q == ST_XFER) || (st_q == ST_LAST);
  assign load_o    = (st_q == ST_IDLE) && start_i;
  assign sample_o  = xfer_tick && (cpha_q ? !leading : leading);
  // phase 1 skips the first leading edge, phase 0 skips the final trailing one
  assign shift_o   = xfer_tick && (cpha_q ? (leading && edge_q != '0)
                                          : (!leading && edge_q != LAST_EDGE));
  assign capture_o = (st_q == ST_LAST) && tick_i;
  assign sclk_o    = sclk_q;
  assign cs_no     = cs_q;
  assign done_o    = done_q;
  assign busy_o    = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      wait_q <= '0;
      edge_q <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          sclk_q <= mode_i[MODE_CPOL_BIT];
          if (start_i) begin
            cpol_q <= mode_i[MODE_CPOL_BIT];
            cpha_q <= mode_i[MODE_CPHA_BIT];
            wait_q <= wait_cycles_i;
            edge_q <= '0;
            cs_q   <= 1'b0;
            st_q   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (wait_q != '0)  wait_q <= wait_q - 1'b1;
          else if (!ready_ni) st_q  <= ST_XFER;
        end
        ST_XFER: begin
          if (tick_i) begin
            sclk_q <= ~sclk_q;
            edge_q <= edge_q + 1'b1;
            if (edge_q == LAST_EDGE) st_q <= ST_LAST;
          end
        end
        ST_LAST: begin
          if (tick_i) begin
            cs_q   <= 1'b1;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_cs_rise_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_q) |-> sclk_q == cpol_q);
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_no_edge_in_setup_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_SETUP |=> $stable(sclk_q));
  assert_ready_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_SETUP && wait_q == '0 && ready_ni |=> st_q == ST_SETUP && cs_q == 1'b0);
  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != ST_IDLE && start_i |=> st_q != ST_SETUP || $past(st_q) == ST_SETUP);
  assert_done_with_cs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> cs_q);
endmodule

// File: rtl/spi_flow_master.sv
module spi_flow_master #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned WAIT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WIDTH-1:0]  tx_data_i,
  input  logic [1:0]        mode_i,
  input  logic              lsb_first_i,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic [WAIT_W-1:0] wait_cycles_i,
  input  logic              ready_ni,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              cs_no,
  output logic [WIDTH-1:0]  rx_data_o,
  output logic              done_o,
  output logic              busy_o
);
  logic run, tick, load, shift, sample, capture;

  spi_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .run_i(run), .half_div_i, .tick_o(tick)
  );

  spi_seq #(.WIDTH(WIDTH), .WAIT_W(WAIT_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .mode_i, .wait_cycles_i, .ready_ni,
    .tick_i(tick), .run_o(run), .load_o(load), .shift_o(shift),
    .sample_o(sample), .capture_o(capture), .sclk_o, .cs_no, .done_o, .busy_o
  );

  spi_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk_i, .rst_ni, .load_i(load), .tx_i(tx_data_i), .lsb_first_i,
    .shift_i(shift), .sample_i(sample), .capture_i(capture), .miso_i,
    .mosi_o, .rx_o(rx_data_o)
  );
endmodule

// File: tb/spi_flow_master_test.sv
module spi_flow_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NVEC = 6;

  // {mode, lsb, tx, slave word, half_div, wait}
  localparam logic [34:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 8'hA5, 8'h3C, 8'd1, 8'd0},
    {2'd1, 1'b0, 8'h96, 8'hF0, 8'd0, 8'd3},
    {2'd2, 1'b1, 8'h81, 8'h5A, 8'd2, 8'd1},
    {2'd3, 1'b1, 8'h7E, 8'hC3, 8'd1, 8'd5},
    {2'd0, 1'b1, 8'h01, 8'h80, 8'd3, 8'd2},
    {2'd3, 1'b0, 8'hFF, 8'h00, 8'd0, 8'd0}
  };

  logic clk = 0, rst_n = 0, start = 0, lsb = 0, ready_n = 0, miso_r = 0;
  logic [W-1:0] tx = 0;
  logic [1:0] mode = 0;
  logic [7:0] hdiv = 0, wt = 0;
  logic sclk, mosi, cs_n, done, busy;
  logic [W-1:0] rx;

  int n_chk = 0, n_fail = 0;

  // behavioural slave
  logic [W-1:0] s_tx = 0, s_rx = 0;
  logic cur_cpol = 0, cur_cpha = 0, cur_lsb = 0;
  int sh_cnt = 0, in_cnt = 0, edges_seen = 0, nb = 0;
  logic lead;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_flow_master uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tx_data_i(tx), .mode_i(mode),
    .lsb_first_i(lsb), .half_div_i(hdiv), .wait_cycles_i(wt), .ready_ni(ready_n),
    .miso_i(miso_r), .sclk_o(sclk), .mosi_o(mosi), .cs_no(cs_n),
    .rx_data_o(rx), .done_o(done), .busy_o(busy)
  );

  function automatic int bpos(int i);
    return cur_lsb ? i : W - 1 - i;
  endfunction

  always @(negedge cs_n) begin
    sh_cnt = 0; in_cnt = 0; edges_seen = 0; s_rx = '0;
    miso_r = s_tx[bpos(0)];
  end

  always @(sclk) begin
    if (!cs_n) begin
      edges_seen++;
      lead = (sclk != cur_cpol);
      if (cur_cpha ? !lead : lead) begin
        if (in_cnt < W) s_rx[bpos(in_cnt)] = mosi;
        in_cnt++;
      end else begin
        nb = cur_cpha ? sh_cnt : sh_cnt + 1;
        if (nb < W) miso_r = s_tx[bpos(nb)];
        sh_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic setup_word(input logic [1:0] m, input logic l, input logic [W-1:0] t,
                            input logic [W-1:0] s, input logic [7:0] d, input logic [7:0] w);
    @(negedge clk);
    mode = m; lsb = l; tx = t; hdiv = d; wt = w;
    s_tx = s; cur_cpol = m[1]; cur_cpha = m[0]; cur_lsb = l;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(input string req, output bit seen);
    seen = 0;
    for (int i = 0; i < 6000 && !seen; i++) begin
      if (done) seen = 1;
      else @(negedge clk);
    end
    check(seen, req, "done seen", int'(seen), 1);
  endtask

  task automatic end_checks(input logic [W-1:0] t, input logic [W-1:0] s,
                            input logic cpol, input string req);
    check(s_rx == t, req, "slave captured mosi", s_rx, t);
    check(rx == s, "R4", "rx_data", rx, s);
    check(cs_n == 1'b1, "R6", "cs high with done", cs_n, 1);
    check(sclk == cpol, "R1", "sclk rest after word", sclk, cpol);
    check(edges_seen == 2 * W, "R5", "sclk transitions", edges_seen, 2 * W);
    @(negedge clk);
    check(done == 1'b0, "R10", "done one cycle", done, 0);
    check(rx == s, "R10", "rx held", rx, s);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit seen;
    int n;
    logic [1:0] m;
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1, "R6", "reset cs", cs_n, 1);
    check(done == 1'b0, "R10", "reset done", done, 0);
    check(busy == 1'b0, "R9", "reset busy", busy, 0);
    check(sclk == 1'b0, "R1", "reset sclk", sclk, 0);
    rst_n = 1;

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      m = VEC[v][34:33];
      setup_word(m, VEC[v][32], VEC[v][31:24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);
      check(sclk == m[1], "R1", "sclk rest before start", sclk, m[1]);
      pulse_start();
      check(cs_n == 1'b0, "R6", "cs low after start", cs_n, 0);
      check(sclk == m[1], "R1", "sclk rest at cs fall", sclk, m[1]);
      check(mosi == (VEC[v][32] ? VEC[v][24] : VEC[v][31]), m[0] ? "R3" : "R2",
            "first bit at cs fall", mosi, VEC[v][32] ? VEC[v][24] : VEC[v][31]);
      wait_done("R6", seen);
      end_checks(VEC[v][31:24], VEC[v][23:16], m[1], m[0] ? "R3" : "R2");
    end

    // exact first-edge latency
    setup_word(2'd1, 1'b0, 8'h5C, 8'hA3, 8'd2, 8'd20);
    pulse_start();
    n = 0;
    while (sclk == 1'b0 && n < 200) begin @(negedge clk); n++; end
    check(n == 20 + 2 + 2, "R7", "cycles to first sclk edge", n, 24);
    wait_done("R7", seen);
    end_checks(8'h5C, 8'hA3, 1'b0, "R3");

    // ready gating
    ready_n = 1;
    setup_word(2'd2, 1'b0, 8'h3B, 8'hD4, 8'd1, 8'd2);
    pulse_start();
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      if (done) seen = 1;
      @(negedge clk);
    end
    check(edges_seen == 0, "R8", "no sclk while not ready", edges_seen, 0);
    check(sclk == 1'b1, "R8", "sclk at rest while not ready", sclk, 1);
    check(cs_n == 1'b0, "R8", "cs held low while not ready", cs_n, 0);
    check(!seen, "R8", "no done while not ready", int'(seen), 0);
    ready_n = 0;
    wait_done("R8", seen);
    end_checks(8'h3B, 8'hD4, 1'b1, "R8");

    // start during busy
    setup_word(2'd0, 1'b0, 8'hC6, 8'h19, 8'd1, 8'd0);
    pulse_start();
    repeat (10) @(negedge clk);
    tx = 8'h2D;
    pulse_start();
    wait_done("R9", seen);
    end_checks(8'hC6, 8'h19, 1'b0, "R9");
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      if (!cs_n) seen = 1;
      @(negedge clk);
    end
    check(!seen, "R9", "no second word", int'(seen), 0);
    check(rx == 8'h19, "R9", "rx unchanged", rx, 8'h19);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule